// File: doc/BRIEF.md
# Clock Calendar Time Counter

This block keeps the time of day and the calendar date inside a larger chip. A once-per-second strobe, one system clock cycle wide, advances the count. Seconds, minutes, hours, day of month, month, two-digit year and a weekday counter each live in their own register. Every register holds packed BCD, so software and display logic can read the values without converting them.

A single-byte write port loads any one field, selected by a three-bit code. A read request copies every field into a snapshot register in the same clock cycle. A rollover in progress therefore can never mix old and new digits in what the host reads.

Hours are presented in 24-hour or 12-hour form, chosen by a mode input. February gets 29 days in every year whose two digits divide by four, which is correct for the whole century. The weekday counter runs on its own, independent of the date: it steps once at every midnight and wraps after seven states.

Top module: `rtc_time_counter`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hour 00 (24-hour mode), date 01, month 01, year 00, weekday 0 and PM flag 0, and `rd_valid` is low.
- R2: Each `sec_tick` pulse advances the seconds in BCD from 00 to 59. A tick at 59 gives 00 and adds one to the minutes. Minutes 59 wrap to 00 and add one to the hour.
- R3: With `mode_12h` low the hour counts 00 to 23, and the step from 23:59:59 wraps it to 00 and starts a new day. The PM flag stays 0 in this mode.
- R4: With `mode_12h` high the hour counts 12, 01, 02 … 11. The PM flag inverts on each step from 11 to 12. The new day starts on the step from 11 PM to 12 AM. An hour write in this mode takes bit 7 as the PM flag and bits 5:0 as the BCD hour.
- R5: The date rolls from the last day of the month back to 01 and adds one to the month. April, June, September and November end on 30, and the other months apart from February end on 31.
- R6: February ends on 29 when the BCD year value divides by four, year 00 included, and on 28 otherwise.
- R7: Month 12 rolls over to 01 and adds one to the year. Year 99 rolls over to 00 while the other fields carry as usual.
- R8: The weekday (3 bits) steps 0,1,…,6,0 once at each day rollover, whatever the date. A written weekday value is kept and counts on from there.
- R9: A write with `wr_en` high loads `wr_data` into the field picked by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday) at the next clock edge. If a tick arrives in the same cycle, the written field takes the written value and the other fields count as normal.
- R10: A tick in the same cycle as a seconds write is dropped. Seconds take the written value, and no carry reaches the minutes.
- R11: A read request copies all fields together in its cycle, taking the values from before any tick in that cycle. `rd_valid` is high on the next cycle, and the snapshot outputs do not change until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe that marks one second |
| mode_12h | input | 1 | High selects the 12-hour hour format |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | BCD value to write |
| rd_req | input | 1 | Snapshot request |
| rd_valid | output | 1 | High one cycle after a request |
| rd_sec | output | 8 | Snapshot seconds, BCD |
| rd_min | output | 8 | Snapshot minutes, BCD |
| rd_hour | output | 8 | Snapshot hour, BCD |
| rd_pm | output | 1 | Snapshot PM flag |
| rd_date | output | 8 | Snapshot day of month, BCD |
| rd_month | output | 8 | Snapshot month, BCD |
| rd_year | output | 8 | Snapshot year, BCD |
| rd_wday | output | 3 | Snapshot weekday |

## Verification
The assertions check on every cycle the local rules of the counting chain:
- a seconds write beats a coincident tick;
- a seconds wrap clears the seconds and moves the minutes;
- nothing moves without a tick or a write;
- the weekday steps by one at each midnight;
- the date and the year restart correctly;
- the snapshot holds between requests.

Only the bench scenarios can show that whole rollovers come out right:
- the month lengths, leap and non-leap Februaries across both parities of the tens digit, and the century wrap;
- the 12-hour sequence with its PM flag;
- a snapshot taken in the same cycle as a full rollover returning the old, untorn time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_WDAY  = 3'd6
  } field_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic       pm;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
    logic [2:0] wday;
  } rtc_time_t;

  // Add one to a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // A BCD year divides by four: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last valid date of a month, in BCD.
  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] y);
    case (mo)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_12h,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       pm,
  output logic       day_wrap
);

  // Named internal events, used by the assertions below.
  logic wr_sec, wr_min, wr_hour;
  logic tick_eff, sec_wrap, min_wrap, hour_last;
  logic [7:0] hour_nxt, hour_rst;
  logic       pm_nxt;

  assign wr_sec   = wr_en && (wr_sel == FLD_SEC);
  assign wr_min   = wr_en && (wr_sel == FLD_MIN);
  assign wr_hour  = wr_en && (wr_sel == FLD_HOUR);
  assign tick_eff = tick && !wr_sec;
  assign sec_wrap = tick_eff && (sec == 8'h59);
  assign min_wrap = sec_wrap && (min == 8'h59);
  assign hour_last = mode_12h ? ((hour == 8'h11) && pm) : (hour == 8'h23);
  assign day_wrap = min_wrap && hour_last;
  assign hour_rst = mode_12h ? 8'h12 : 8'h00;

  always_comb begin
    hour_nxt = bcd_inc(hour);
    pm_nxt   = 1'b0;
    if (mode_12h) begin
      pm_nxt = pm;
      if (hour == 8'h12) hour_nxt = 8'h01;
      if (hour == 8'h11) pm_nxt = ~pm;
    end else if (hour == 8'h23) begin
      hour_nxt = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= hour_rst;
      pm   <= 1'b0;
    end else begin
      if (wr_sec)        sec <= wr_data;
      else if (tick_eff) sec <= sec_wrap ? 8'h00 : bcd_inc(sec);

      if (wr_min)        min <= wr_data;
      else if (sec_wrap) min <= min_wrap ? 8'h00 : bcd_inc(min);

      if (wr_hour) begin
        hour <= {2'b00, wr_data[5:0]};
        pm   <= mode_12h && wr_data[7];
      end else if (min_wrap) begin
        hour <= hour_nxt;
        pm   <= pm_nxt;
      end
    end
  end

  assert_tick_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sec && tick) |=> (sec == $past(wr_data)) && $stable(min));

  assert_sec_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !wr_min) |=> (sec == 8'h00) && (min != $past(min)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec) && $stable(min) && $stable(hour) && $stable(pm));

  assert_pm_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_12h && (wr_hour || min_wrap)) |=> !pm);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int WDAY_COUNT = 7,
  localparam int WDAY_W    = $clog2(WDAY_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_wrap,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        date,
  output logic [7:0]        month,
  output logic [7:0]        year,
  output logic [WDAY_W-1:0] wday
);

  localparam logic [WDAY_W-1:0] WDAY_LAST = WDAY_W'(WDAY_COUNT - 1);

  logic wr_date, wr_month, wr_year, wr_wday;
  logic date_wrap, mon_wrap, year_wrap;
  logic [7:0] date_last;

  assign wr_date   = wr_en && (wr_sel == FLD_DATE);
  assign wr_month  = wr_en && (wr_sel == FLD_MONTH);
  assign wr_year   = wr_en && (wr_sel == FLD_YEAR);
  assign wr_wday   = wr_en && (wr_sel == FLD_WDAY);
  assign date_last = month_last(month, year);
  assign date_wrap = day_wrap && (date == date_last);
  assign mon_wrap  = date_wrap && (month == 8'h12);
  assign year_wrap = mon_wrap && (year == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
      wday  <= '0;
    end else begin
      if (wr_date)       date <= wr_data;
      else if (day_wrap) date <= date_wrap ? 8'h01 : bcd_inc(date);

      if (wr_month)       month <= wr_data;
      else if (date_wrap) month <= mon_wrap ? 8'h01 : bcd_inc(month);

      if (wr_year)       year <= wr_data;
      else if (mon_wrap) year <= year_wrap ? 8'h00 : bcd_inc(year);

      if (wr_wday)       wday <= wr_data[WDAY_W-1:0];
      else if (day_wrap) wday <= (wday == WDAY_LAST) ? '0 : wday + 1'b1;
    end
  end

  assert_wday_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_wrap && !wr_wday) |=>
      (wday == (($past(wday) == WDAY_LAST) ? '0 : $past(wday) + 1'b1)));

  assert_date_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !wr_date) |=> (date == 8'h01));

  assert_century_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !wr_year && !wr_month) |=> (year == 8'h00) && (month == 8'h01));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_req,
  input  rtc_time_t cur,
  output rtc_time_t snap,
  output logic      rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) snap <= cur;
    end
  end

  assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(snap) && !rd_valid);

  assert_snap_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid && (snap == $past(cur)));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       mode_12h,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic       rd_pm,
  output logic [7:0] rd_date,
  output logic [7:0] rd_month,
  output logic [7:0] rd_year,
  output logic [2:0] rd_wday
);

  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] wday;
  logic       pm, day_wrap;
  rtc_time_t  cur, snap;

  rtc_clock_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .mode_12h(mode_12h),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec(sec), .min(min), .hour(hour), .pm(pm), .day_wrap(day_wrap)
  );

  rtc_calendar #(.WDAY_COUNT(7)) u_cal (
    .clk(clk), .rst_n(rst_n), .day_wrap(day_wrap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .date(date), .month(month), .year(year), .wday(wday)
  );

  always_comb begin
    cur.sec   = sec;
    cur.min   = min;
    cur.hour  = hour;
    cur.pm    = pm;
    cur.date  = date;
    cur.month = month;
    cur.year  = year;
    cur.wday  = wday;
  end

  rtc_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cur(cur),
    .snap(snap), .rd_valid(rd_valid)
  );

  assign rd_sec   = snap.sec;
  assign rd_min   = snap.min;
  assign rd_hour  = snap.hour;
  assign rd_pm    = snap.pm;
  assign rd_date  = snap.date;
  assign rd_month = snap.month;
  assign rd_year  = snap.year;
  assign rd_wday  = snap.wday;

endmodule

// File: tb/rtc_time_counter_bench.sv
module rtc_time_counter_bench;
  import rtc_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, sec_tick, mode_12h, wr_en, rd_req;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic       rd_valid, rd_pm;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year;
  logic [2:0] rd_wday;

  rtc_time_counter u_rtc_time_counter (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .mode_12h(mode_12h),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour),
    .rd_pm(rd_pm), .rd_date(rd_date), .rd_month(rd_month), .rd_year(rd_year),
    .rd_wday(rd_wday)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  rtc_time_t exp_q[$];
  string     tag_q[$];

  // Reference model kept in plain binary integers with a 24-hour clock.
  int s, m, h, d, mo, y, wd;
  bit m12;

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) * 16) + (n % 10));
  endfunction

  function automatic int days_in(input int mon, input int yr);
    case (mon)
      2:            return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11:  return 30;
      default:      return 31;
    endcase
  endfunction

  function automatic int h12_of(input int hh);
    return (hh % 12 == 0) ? 12 : hh % 12;
  endfunction

  task automatic model_tick();
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) begin
      h = 0; wd = (wd + 1) % 7; d++;
      if (d > days_in(mo, y)) begin d = 1; mo++; end
      if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
    end
  endtask

  function automatic rtc_time_t model_exp();
    rtc_time_t e;
    e.sec   = to_bcd(s);
    e.min   = to_bcd(m);
    e.hour  = m12 ? to_bcd(h12_of(h)) : to_bcd(h);
    e.pm    = m12 && (h >= 12);
    e.date  = to_bcd(d);
    e.month = to_bcd(mo);
    e.year  = to_bcd(y);
    e.wday  = 3'(wd);
    return e;
  endfunction

  function automatic rtc_time_t port_snap();
    rtc_time_t g;
    g.sec = rd_sec; g.min = rd_min; g.hour = rd_hour; g.pm = rd_pm;
    g.date = rd_date; g.month = rd_month; g.year = rd_year; g.wday = rd_wday;
    return g;
  endfunction

  task automatic compare(input rtc_time_t got, input rtc_time_t exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops one expected snapshot per rd_valid pulse.
  always @(negedge clk) begin
    if (rst_n && rd_valid && !done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: rd_valid with nothing expected, got %h expected none", port_snap());
      end else begin
        compare(port_snap(), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic do_write(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    model_tick();
  endtask

  task automatic do_read(input string tag);
    @(negedge clk);
    rd_req = 1'b1;
    exp_q.push_back(model_exp());
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  function automatic logic [7:0] hour_code();
    if (m12) return ((h >= 12) ? 8'h80 : 8'h00) | to_bcd(h12_of(h));
    return to_bcd(h);
  endfunction

  task automatic set_all(input int hh, input int mm, input int ss, input int dd,
                         input int mon, input int yr, input int wk);
    h = hh; m = mm; s = ss; d = dd; mo = mon; y = yr; wd = wk;
    do_write(3'd0, to_bcd(s));
    do_write(3'd1, to_bcd(m));
    do_write(3'd2, hour_code());
    do_write(3'd3, to_bcd(d));
    do_write(3'd4, to_bcd(mo));
    do_write(3'd5, to_bcd(y));
    do_write(3'd6, 8'(wd));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rtc_time_t held;
    rst_n = 1'b0; sec_tick = 1'b0; mode_12h = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_data = '0; rd_req = 1'b0; m12 = 0;
    s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0; wd = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rd_valid got %b expected 0", rd_valid);
    end
    rst_n = 1'b1;
    do_read("R1 reset state");

    // R2 seconds and minute carry
    set_all(0, 0, 58, 1, 1, 0, 0);
    repeat (3) do_tick();
    do_read("R2 seconds carry into minutes");
    set_all(5, 59, 59, 10, 3, 5, 2);
    do_tick();
    do_read("R2 minutes carry into hour");

    // R3 / R6 non-leap, tens even
    set_all(23, 59, 59, 28, 2, 23, 3);
    do_tick();
    do_read("R3 R6 midnight, Feb 28 non-leap year 23");
    // R6 non-leap, tens odd
    set_all(23, 59, 59, 28, 2, 10, 1);
    do_tick();
    do_read("R6 Feb 28 non-leap year 10");
    // R6 leap years
    set_all(23, 59, 59, 28, 2, 24, 4);
    do_tick();
    do_read("R6 Feb 28 to 29 leap year 24");
    set_all(23, 59, 59, 29, 2, 24, 5);
    do_tick();
    do_read("R6 Feb 29 to Mar 01 year 24");
    set_all(23, 59, 59, 28, 2, 0, 0);
    do_tick();
    do_read("R6 leap year 00");
    set_all(23, 59, 59, 28, 2, 36, 6);
    do_tick();
    do_read("R6 leap year 36 R8 weekday wrap");

    // R5 month lengths
    set_all(23, 59, 59, 30, 4, 50, 2);
    do_tick();
    do_read("R5 Apr 30 to May 01");
    set_all(23, 59, 59, 30, 1, 50, 2);
    do_tick();
    do_read("R5 Jan 30 to Jan 31");
    do_tick();
    do_read("R5 one tick no date change");

    // R7 century wrap and R8 weekday wrap
    set_all(23, 59, 59, 31, 12, 99, 6);
    do_tick();
    do_read("R7 R8 year 99 to 00");

    // R10 tick coinciding with seconds write
    set_all(8, 10, 59, 5, 5, 5, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h20; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    s = 20;
    do_read("R10 tick dropped on seconds write");

    // R9 write to minutes with a tick, seconds still carry
    set_all(8, 10, 59, 5, 5, 5, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    s = 0; m = 33;
    do_read("R9 minute write wins over carry");

    // R11 snapshot in the same cycle as a full rollover
    set_all(23, 59, 59, 31, 12, 99, 6);
    @(negedge clk);
    sec_tick = 1'b1; rd_req = 1'b1;
    exp_q.push_back(model_exp());
    tag_q.push_back("R11 snapshot taken before tick");
    @(negedge clk);
    sec_tick = 1'b0; rd_req = 1'b0;
    model_tick();
    do_read("R11 snapshot after rollover");
    held = model_exp();
    repeat (4) do_tick();
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++; $display("FAIL R11: rd_valid got %b expected 0", rd_valid);
    end
    compare(port_snap(), held, "R11 snapshot held without request");

    // R4 12-hour mode
    @(negedge clk);
    mode_12h = 1'b1; m12 = 1;
    set_all(11, 59, 59, 14, 6, 7, 3);
    do_tick();
    do_read("R4 11 AM to 12 PM");
    set_all(12, 59, 59, 14, 6, 7, 3);
    do_tick();
    do_read("R4 12 PM to 01 PM");
    set_all(23, 59, 59, 14, 6, 7, 3);
    do_tick();
    do_read("R4 11 PM to 12 AM new day");
    set_all(0, 59, 59, 15, 6, 7, 4);
    do_tick();
    do_read("R4 12 AM to 01 AM");

    // R3 back in 24-hour mode, PM flag cleared by hour write
    @(negedge clk);
    mode_12h = 1'b0; m12 = 0;
    set_all(13, 59, 59, 15, 6, 7, 4);
    do_tick();
    do_read("R3 24-hour 13 to 14 with flag clear");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: pending snapshots got %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule